// File: doc/BRIEF.md
# Configurable Burst Memory Access Sequencer

This block sits between a command port and a synchronous memory array. Its configuration arrives through a mode-register write. That write is a run of bus cycles marked by a cycle strobe, with a separate marker on the first cycle. The byte on the data bus in the fourth cycle of the run sets these fields: how much of the array is kept during power-down, the burst length, the choice between page and burst operation, and which edge of the memory clock is active. The byte in the fifth cycle sets the read latency and the choice between single and burst writes. The write latency is always one less than the read latency.

In burst operation the sequencer accepts a read or write command on an active edge of the memory clock. It then counts the programmed latency in further active edges and emits one data-valid strobe per word. Each strobe comes with the burst address for that word, which starts at the command address and rises by one per word. The burst stops after the programmed length, or runs until a stop request when the length is continuous. The memory clock is an ordinary input that the system clock samples. Both of its edges are detected, and the programmed edge bit picks which one counts, so the whole design runs on one clock.

Top module: `burst_seq_ctrl`

## Requirements
- R1: After reset: page operation (cfg_page=1), rising edge (cfg_rise=1), read latency 5, write latency 4, burst length 8, burst writes (cfg_single=0), retention code 00, busy=0, both strobes 0, bst_addr=0.
- R2: Each clock with mr_cyc=1 is one mode-register cycle. mr_first=1 marks cycle 1, and cycles are numbered upward from there. The count returns to zero after cycle 5. Only cycles 4 and 5 change the configuration, and cycles 1 to 3 have no effect on it.
- R3: In cycle 4, dq_in[4:2]=010 sets cfg_len=8, 011 sets 16 and 111 sets continuous (cfg_len=0). Any other code leaves cfg_len unchanged.
- R4: In cycle 4, dq_in[5]=1 selects page operation and 0 selects burst operation. In page operation, commands are ignored and busy stays 0.
- R5: In cycle 4, dq_in[6]=1 makes a rising edge of mem_clk the active edge, and 0 makes a falling edge the active edge. Commands, stops and words all advance only on active edges.
- R6: In cycle 5, dq_in[2:0] codes 2 to 7 set cfg_rl to code+3 (5 to 10). Codes 0 and 1 leave it unchanged. cfg_wl always equals cfg_rl-1.
- R7: In cycle 5, dq_in[3]=1 selects single write, where a write command moves exactly one word. dq_in[3]=0 selects burst writes.
- R8: When pd_n=0, retain_mbit shows the programmed retention for dq_in[1:0] of cycle 4: 00 gives 32, 01 gives 16, 10 gives 8 and 11 gives 0. When pd_n=1, retain_mbit is 0.
- R9: A read accepted on an active edge produces its first rd_stb one clock after the cfg_rl-th later active edge. After that it produces one rd_stb per active edge, with bst_addr equal to the base address plus the word index. It produces exactly cfg_len words and then busy drops.
- R10: A write behaves like a read but counts cfg_wl active edges and drives wr_stb. In single-write mode it moves one word.
- R11: A burst_stop sampled on an active edge during latency or transfer ends the burst with no word at that edge. It is the only way a continuous burst ends.
- R12: A command that arrives while busy=1 is ignored.
- R13: rd_stb and wr_stb are never high together, and each pulse lasts one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mr_cyc | input | 1 | Mode-register bus cycle strobe |
| mr_first | input | 1 | Marks cycle 1 of a mode-register run |
| dq_in | input | DQ_W | Data bus carrying configuration bytes |
| pd_n | input | 1 | Power-down control, low = powered down |
| mem_clk | input | 1 | Memory clock, sampled by clk |
| cmd_valid | input | 1 | Command request |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Burst start address |
| burst_stop | input | 1 | Ends the running burst |
| busy | output | 1 | Burst in latency or transfer |
| rd_stb | output | 1 | Read data-valid strobe |
| wr_stb | output | 1 | Write data-valid strobe |
| bst_addr | output | ADDR_W | Address of the word being strobed |
| cfg_page | output | 1 | Page operation selected |
| cfg_rise | output | 1 | Rising edge active |
| cfg_rl | output | 4 | Read latency in active edges |
| cfg_wl | output | 4 | Write latency in active edges |
| cfg_len | output | 5 | Burst length, 0 = continuous |
| cfg_single | output | 1 | Single-write mode |
| retain_mbit | output | 6 | Mbit retained in power-down |

## Verification
The configuration outputs change on the clock edge that samples the fourth or fifth mode-register cycle, and they are visible from that edge on. retain_mbit follows pd_n in the same cycle. A strobe and its address appear one clock after the active edge that carries the word, and busy drops on that same edge for the last word. The bench runs a behavioural model on every rising clock edge. It drives inputs a quarter period after that edge and compares every output at the falling edge, so each result is sampled in the cycle it is due.

// File: rtl/bseq_pkg.sv
// Shared types and decode helpers for the burst sequencer.
// Assumes: latency codes below 2 and unlisted length codes are reserved.
package bseq_pkg;

    localparam int LAT_W = 4;
    localparam int LEN_W = 5;
    localparam int RET_W = 6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_XFER = 2'd2
    } bseq_state_t;

    typedef struct packed {
        logic [1:0]       keep_code;
        logic [LEN_W-1:0] len;
        logic             page;
        logic             rise;
        logic [LAT_W-1:0] rl;
        logic             single;
    } bseq_cfg_t;

    // Burst length from its 3-bit code; unlisted codes keep the old value.
    function automatic logic [LEN_W-1:0] len_decode(input logic [2:0] code,
                                                    input logic [LEN_W-1:0] prev);
        case (code)
            3'b010:  return LEN_W'(8);
            3'b011:  return LEN_W'(16);
            3'b111:  return '0;
            default: return prev;
        endcase
    endfunction

    // Read latency from its 3-bit code; codes 0 and 1 keep the old value.
    function automatic logic [LAT_W-1:0] rl_decode(input logic [2:0] code,
                                                   input logic [LAT_W-1:0] prev);
        if (code >= 3'd2) return {1'b0, code} + LAT_W'(3);
        return prev;
    endfunction

    // Retained size in Mbit for a retention code.
    function automatic logic [RET_W-1:0] keep_mbit(input logic [1:0] code);
        case (code)
            2'b00:   return RET_W'(32);
            2'b01:   return RET_W'(16);
            2'b10:   return RET_W'(8);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/bseq_mode_reg.sv
// Mode-register capture: counts the bus cycles of a register-set run and
// decodes the bytes seen in cycles 4 and 5 into the configuration struct.
// Assumes: mr_first marks cycle 1; without it cycles are counted on from
// the last one, returning to zero after cycle 5.
module bseq_mode_reg
    import bseq_pkg::*;
#(
    parameter int DQ_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mr_cyc,
    input  logic            mr_first,
    input  logic [DQ_W-1:0] dq,
    output bseq_cfg_t       cfg
);

    localparam int IDX_W = 3;

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] num;
    logic             unused_dq;

    assign unused_dq = ^dq[DQ_W-1:7];

    // Number of the cycle being presented now.
    always_comb num = mr_first ? IDX_W'(1) : idx_q + IDX_W'(1);

    // Track position within the run.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (mr_cyc)
            idx_q <= (num >= IDX_W'(5)) ? '0 : num;
    end

    // Capture and decode the two configuration bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.keep_code <= 2'b00;
            cfg.len       <= LEN_W'(8);
            cfg.page      <= 1'b1;
            cfg.rise      <= 1'b1;
            cfg.rl        <= LAT_W'(5);
            cfg.single    <= 1'b0;
        end else if (mr_cyc && num == IDX_W'(4)) begin
            cfg.keep_code <= dq[1:0];
            cfg.len       <= len_decode(dq[4:2], cfg.len);
            cfg.page      <= dq[5];
            cfg.rise      <= dq[6];
        end else if (mr_cyc && num == IDX_W'(5)) begin
            cfg.rl        <= rl_decode(dq[2:0], cfg.rl);
            cfg.single    <= dq[3];
        end
    end

endmodule

// File: rtl/bseq_edge_qual.sv
// Active-edge qualifier: samples the memory clock with the system clock,
// detects both of its edges and passes on only the one selected.
// Assumes: mem_clk is synchronous to clk and stays stable for at least
// one clk period per phase.
module bseq_edge_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic mem_clk,
    input  logic rise_sel,
    output logic tick
);

    logic       prev_q;
    logic [1:0] edge_hit;

    // Remember the previous sample of the memory clock.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= mem_clk;
    end

    // One detector per polarity: index 0 falling, index 1 rising.
    for (genvar p = 0; p < 2; p++) begin : g_pol
        if (p == 0) begin : g_fall
            assign edge_hit[p] = !mem_clk && prev_q;
        end else begin : g_rise
            assign edge_hit[p] = mem_clk && !prev_q;
        end
    end

    assign tick = edge_hit[rise_sel];

endmodule

// File: rtl/bseq_burst_engine.sv
// Burst engine: accepts a command on an active edge, counts the latency,
// then strobes one word per active edge with a rising address until the
// length is reached or a stop arrives.
// Assumes: configuration is steady while a burst runs; length and latency
// are latched when the command is accepted.
module bseq_burst_engine
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              burst_stop,
    input  bseq_cfg_t         cfg,
    output logic              busy,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] bst_addr
);

    localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(1);
    localparam logic [LEN_W-1:0]  ONE_WORD  = LEN_W'(1);
    localparam logic [LAT_W-1:0]  ONE_LAT   = LAT_W'(1);

    bseq_state_t       state_q;
    logic              is_wr_q;
    logic              endless_q;
    logic [LAT_W-1:0]  lat_left_q;
    logic [LEN_W-1:0]  words_left_q;
    logic [ADDR_W-1:0] cur_addr_q;
    logic              take;
    logic              emit;
    logic              last_word;

    // Accept only when idle, on an active edge, in burst operation.
    always_comb take = (state_q == ST_IDLE) && tick && cmd_valid && !cfg.page;

    // A word moves on an active edge once latency has run out.
    always_comb emit = tick && !burst_stop &&
                       (((state_q == ST_WAIT) && (lat_left_q == ONE_LAT)) ||
                        (state_q == ST_XFER));

    always_comb last_word = !endless_q && (words_left_q == ONE_WORD);

    // Sequence control: idle, latency wait, transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            is_wr_q      <= 1'b0;
            endless_q    <= 1'b0;
            lat_left_q   <= '0;
            words_left_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (take) begin
                        state_q    <= ST_WAIT;
                        is_wr_q    <= cmd_write;
                        lat_left_q <= cmd_write ? cfg.rl - ONE_LAT : cfg.rl;
                        if (cmd_write && cfg.single) begin
                            words_left_q <= ONE_WORD;
                            endless_q    <= 1'b0;
                        end else begin
                            words_left_q <= cfg.len;
                            endless_q    <= (cfg.len == '0);
                        end
                    end
                end
                ST_WAIT: begin
                    if (tick) begin
                        if (burst_stop)
                            state_q <= ST_IDLE;
                        else if (lat_left_q == ONE_LAT)
                            state_q <= last_word ? ST_IDLE : ST_XFER;
                        else
                            lat_left_q <= lat_left_q - ONE_LAT;
                    end
                end
                ST_XFER: begin
                    if (tick && (burst_stop || last_word))
                        state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
            if (emit)
                words_left_q <= words_left_q - ONE_WORD;
        end
    end

    // Address stepping and data-valid strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr_q <= '0;
            bst_addr   <= '0;
            rd_stb     <= 1'b0;
            wr_stb     <= 1'b0;
        end else begin
            rd_stb <= emit && !is_wr_q;
            wr_stb <= emit && is_wr_q;
            if (take)
                cur_addr_q <= cmd_addr;
            else if (emit) begin
                bst_addr   <= cur_addr_q;
                cur_addr_q <= cur_addr_q + ADDR_STEP;
            end
        end
    end

    assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/burst_seq_ctrl.sv
// Top of the burst sequencer: mode-register capture, memory-clock edge
// qualification and the burst engine, plus the configuration outputs.
// Assumes: unlock cycles before the register-set run are handled outside.
module burst_seq_ctrl
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DQ_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mr_cyc,
    input  logic              mr_first,
    input  logic [DQ_W-1:0]   dq_in,
    input  logic              pd_n,
    input  logic              mem_clk,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              burst_stop,
    output logic              busy,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] bst_addr,
    output logic              cfg_page,
    output logic              cfg_rise,
    output logic [3:0]        cfg_rl,
    output logic [3:0]        cfg_wl,
    output logic [4:0]        cfg_len,
    output logic              cfg_single,
    output logic [5:0]        retain_mbit
);

    bseq_cfg_t cfg;
    logic      tick;

    bseq_mode_reg #(.DQ_W(DQ_W)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .mr_cyc   (mr_cyc),
        .mr_first (mr_first),
        .dq       (dq_in),
        .cfg      (cfg)
    );

    bseq_edge_qual u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .mem_clk  (mem_clk),
        .rise_sel (cfg.rise),
        .tick     (tick)
    );

    bseq_burst_engine #(.ADDR_W(ADDR_W)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .cmd_valid  (cmd_valid),
        .cmd_write  (cmd_write),
        .cmd_addr   (cmd_addr),
        .burst_stop (burst_stop),
        .cfg        (cfg),
        .busy       (busy),
        .rd_stb     (rd_stb),
        .wr_stb     (wr_stb),
        .bst_addr   (bst_addr)
    );

    // Configuration visible at the ports; write latency trails read by one.
    assign cfg_page    = cfg.page;
    assign cfg_rise    = cfg.rise;
    assign cfg_rl      = cfg.rl;
    assign cfg_wl      = cfg.rl - 4'd1;
    assign cfg_len     = cfg.len;
    assign cfg_single  = cfg.single;
    assign retain_mbit = pd_n ? '0 : keep_mbit(cfg.keep_code);

endmodule

// File: rtl/bseq_checker.sv
// Property checker for burst_seq_ctrl, attached by bind below.
module bseq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       pd_n,
    input logic       busy,
    input logic       rd_stb,
    input logic       wr_stb,
    input logic       cfg_page,
    input logic [3:0] cfg_rl,
    input logic [4:0] cfg_len,
    input logic [5:0] retain_mbit
);

    assert_strobe_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_stb, wr_stb}));

    assert_rd_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> !rd_stb);

    assert_wr_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    assert_len_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_len == 5'd0) || (cfg_len == 5'd8) || (cfg_len == 5'd16));

    assert_rl_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rl >= 4'd5) && (cfg_rl <= 4'd10));

    assert_page_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_page && !busy) |=> !busy);

    assert_rd_in_burst_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |-> $past(busy));

    assert_wr_in_burst_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(busy));

    assert_awake_retain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pd_n |-> (retain_mbit == 6'd0));

endmodule

bind burst_seq_ctrl bseq_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pd_n        (pd_n),
    .busy        (busy),
    .rd_stb      (rd_stb),
    .wr_stb      (wr_stb),
    .cfg_page    (cfg_page),
    .cfg_rl      (cfg_rl),
    .cfg_len     (cfg_len),
    .retain_mbit (retain_mbit)
);

// File: tb/burst_seq_ctrl_test.sv
`timescale 1ns/1ps
module burst_seq_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mr_cyc = 1'b0, mr_first = 1'b0;
    logic [7:0]  dq_in = 8'h00;
    logic        pd_n = 1'b1;
    logic        mem_clk = 1'b0;
    logic        cmd_valid = 1'b0, cmd_write = 1'b0;
    logic [15:0] cmd_addr = 16'h0;
    logic        burst_stop = 1'b0;
    logic        busy, rd_stb, wr_stb, cfg_page, cfg_rise, cfg_single;
    logic [15:0] bst_addr;
    logic [3:0]  cfg_rl, cfg_wl;
    logic [4:0]  cfg_len;
    logic [5:0]  retain_mbit;

    burst_seq_ctrl uut (.*);

    always #10 clk = ~clk;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    int obs_rd = 0, obs_wr = 0;
    bit done = 0;

    // Behavioural reference state
    bit m_ok = 0;
    int m_page, m_rise, m_rl, m_len, m_single, m_keep, m_idx;
    int m_prev, m_busy, m_wrd, m_base, m_ticks, m_lat, m_n;
    int m_rd, m_wr, m_addr, num, code, k;
    bit tk;

    task automatic cmp(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic int keep_size(input int c);
        case (c)
            0: return 32;
            1: return 16;
            2: return 8;
            default: return 0;
        endcase
    endfunction

    // Reference model, advanced on every rising clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ok = 1; m_page = 1; m_rise = 1; m_rl = 5; m_len = 8; m_single = 0;
            m_keep = 0; m_idx = 0; m_prev = 0; m_busy = 0; m_rd = 0; m_wr = 0; m_addr = 0;
        end else begin
            tk = m_rise ? (mem_clk && m_prev == 0) : (!mem_clk && m_prev == 1);
            m_prev = mem_clk;
            m_rd = 0; m_wr = 0;
            if (m_busy) begin
                if (tk) begin
                    m_ticks++;
                    if (burst_stop) m_busy = 0;
                    else if (m_ticks >= m_lat) begin
                        k = m_ticks - m_lat;
                        m_addr = (m_base + k) & 16'hFFFF;
                        if (m_wrd) m_wr = 1; else m_rd = 1;
                        if (m_n != 0 && k == m_n - 1) m_busy = 0;
                    end
                end
            end else if (tk && cmd_valid && !m_page) begin
                m_busy = 1; m_ticks = 0; m_wrd = cmd_write; m_base = cmd_addr;
                m_lat = cmd_write ? m_rl - 1 : m_rl;
                m_n = (cmd_write && m_single) ? 1 : m_len;
            end
            if (mr_cyc) begin
                num = mr_first ? 1 : m_idx + 1;
                if (num == 4) begin
                    m_keep = dq_in[1:0];
                    code = dq_in[4:2];
                    if (code == 2) m_len = 8;
                    else if (code == 3) m_len = 16;
                    else if (code == 7) m_len = 0;
                    m_page = dq_in[5];
                    m_rise = dq_in[6];
                end else if (num == 5) begin
                    code = dq_in[2:0];
                    if (code >= 2) m_rl = code + 3;
                    m_single = dq_in[3];
                end
                m_idx = (num >= 5) ? 0 : num;
            end
        end
    end

    // Compare every output on the falling edge; watchdog.
    always @(negedge clk) begin
        cyc++;
        if (m_ok) begin
            cmp("R9 rd_stb", rd_stb, m_rd);
            cmp("R10 wr_stb", wr_stb, m_wr);
            cmp("R12 busy", busy, m_busy);
            cmp("R9 bst_addr", bst_addr, m_addr);
            cmp("R4 cfg_page", cfg_page, m_page);
            cmp("R5 cfg_rise", cfg_rise, m_rise);
            cmp("R6 cfg_rl", cfg_rl, m_rl);
            cmp("R6 cfg_wl", cfg_wl, m_rl - 1);
            cmp("R3 cfg_len", cfg_len, m_len);
            cmp("R7 cfg_single", cfg_single, m_single);
            cmp("R8 retain", retain_mbit, pd_n ? 0 : keep_size(m_keep));
            cmp("R13 strobe overlap", rd_stb && wr_stb, 0);
            if (rd_stb) obs_rd++;
            if (wr_stb) obs_wr++;
        end
        if (cyc > 150000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Memory clock: toggles every two system clocks.
    int mc_div = 0;
    always @(posedge clk) begin
        #5;
        mc_div++;
        if (mc_div == 2) begin
            mc_div = 0;
            mem_clk = ~mem_clk;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic mr_run(input logic [7:0] a, input logic [7:0] b);
        for (int i = 1; i <= 5; i++) begin
            mr_cyc = 1'b1;
            mr_first = (i == 1);
            dq_in = (i == 4) ? a : (i == 5) ? b : 8'hFF;
            wait_clk(1);
        end
        mr_cyc = 1'b0; mr_first = 1'b0; dq_in = 8'h00;
    endtask

    task automatic issue(input logic wr, input logic [15:0] addr);
        cmd_valid = 1'b1; cmd_write = wr; cmd_addr = addr;
        wait_clk(5);
        cmd_valid = 1'b0;
    endtask

    int r0, w0;

    initial begin
        wait_clk(3);
        rst_n = 1'b1;
        // R1 reset values
        cmp("R1 page", cfg_page, 1); cmp("R1 rise", cfg_rise, 1);
        cmp("R1 rl", cfg_rl, 5); cmp("R1 wl", cfg_wl, 4);
        cmp("R1 len", cfg_len, 8); cmp("R1 single", cfg_single, 0);
        cmp("R1 busy", busy, 0); cmp("R1 strobes", rd_stb | wr_stb, 0);

        // R4 page operation after reset: command ignored
        issue(1'b0, 16'h0040);
        wait_clk(40);
        cmp("R4 page ignores cmd", obs_rd, 0);

        // R2 burst op, rising, len 8, keep 16M; RL 5, burst writes
        mr_run(8'h49, 8'h02);
        cmp("R2 cycle4 len", cfg_len, 8); cmp("R2 cycle4 page", cfg_page, 0);
        cmp("R2 cycle5 rl", cfg_rl, 5);
        pd_n = 1'b0; wait_clk(1);
        cmp("R8 keep 16", retain_mbit, 16);
        pd_n = 1'b1; wait_clk(1);
        cmp("R8 awake", retain_mbit, 0);

        // R9 read burst of 8
        r0 = obs_rd;
        issue(1'b0, 16'h0100);
        wait_clk(70);
        cmp("R9 read words", obs_rd - r0, 8);
        cmp("R9 last addr", bst_addr, 16'h0107);

        // R10 write burst of 8, with R12 a stray command mid-burst
        w0 = obs_wr; r0 = obs_rd;
        issue(1'b1, 16'h2000);
        wait_clk(12);
        issue(1'b0, 16'h3000);
        wait_clk(60);
        cmp("R10 write words", obs_wr - w0, 8);
        cmp("R12 stray read ignored", obs_rd - r0, 0);

        // R5 falling edge, len 16, keep 8M; RL 10, single write
        mr_run(8'h0E, 8'h0F);
        cmp("R5 falling", cfg_rise, 0); cmp("R6 rl 10", cfg_rl, 10);
        cmp("R7 single", cfg_single, 1);
        pd_n = 1'b0; wait_clk(1);
        cmp("R8 keep 8", retain_mbit, 8);
        pd_n = 1'b1;
        r0 = obs_rd;
        issue(1'b0, 16'hFFF8);
        wait_clk(130);
        cmp("R9 read 16 words", obs_rd - r0, 16);
        cmp("R9 addr wrap", bst_addr, 16'h0007);
        w0 = obs_wr;
        issue(1'b1, 16'h0500);
        wait_clk(60);
        cmp("R7 single write", obs_wr - w0, 1);

        // R3/R6 reserved codes keep previous values
        mr_run(8'h16, 8'h00);
        cmp("R3 reserved len kept", cfg_len, 16);
        cmp("R6 reserved rl kept", cfg_rl, 10);

        // R11 continuous burst, rising, RL 6, stopped by request
        mr_run(8'h5C, 8'h03);
        cmp("R3 continuous", cfg_len, 0);
        pd_n = 1'b0; wait_clk(1);
        cmp("R8 keep 32", retain_mbit, 32);
        pd_n = 1'b1;
        r0 = obs_rd;
        issue(1'b0, 16'h4000);
        wait_clk(120);
        cmp("R11 still running", busy, 1);
        burst_stop = 1'b1; wait_clk(6); burst_stop = 1'b0;
        wait_clk(4);
        cmp("R11 stopped", busy, 0);
        cmp("R11 ran past 16", (obs_rd - r0) > 16, 1);

        // R11 stop during latency gives no word
        r0 = obs_rd;
        issue(1'b0, 16'h4800);
        burst_stop = 1'b1; wait_clk(6); burst_stop = 1'b0;
        wait_clk(40);
        cmp("R11 stop in latency", obs_rd - r0, 0);

        // R2 resync: partial run then restart with mr_first
        mr_cyc = 1'b1; mr_first = 1'b1; dq_in = 8'hFF; wait_clk(1);
        mr_first = 1'b0; wait_clk(1);
        mr_cyc = 1'b0; wait_clk(2);
        mr_run(8'h6B, 8'h04);
        cmp("R2 resync page", cfg_page, 1);
        cmp("R2 resync rl", cfg_rl, 7);
        pd_n = 1'b0; wait_clk(1);
        cmp("R8 keep none", retain_mbit, 0);
        pd_n = 1'b1;
        r0 = obs_rd;
        issue(1'b0, 16'h0010);
        wait_clk(60);
        cmp("R4 page mode ignores", obs_rd - r0, 0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule